// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine moves received Ethernet frame bytes into memory buffers. Software prepares a ring of 8-byte receive descriptors and hands each one to the hardware by setting its empty bit. Each descriptor holds a flags halfword, a length halfword and a buffer pointer. When a frame starts, the engine reads the descriptor at its ring pointer over a simple 32-bit memory port. If the hardware owns that descriptor, it writes the frame bytes one at a time into the buffer. A frame longer than the programmed buffer size spills over into the following descriptors.

When a buffer is closed, the engine writes back its status and length word and returns the descriptor to software. It then steps to the next descriptor, or goes back to the ring base when the descriptor asks for a wrap. Buffer, frame and busy events are latched and cleared by writing 1. They drive one interrupt line through per-event masks. If the engine finds a descriptor that software still holds, it drops the rest of that frame, flags busy, and tries the same descriptor again on the next frame.

Top module: `rxbd_ring_engine`

## Requirements
- R1: A descriptor at address A is two big-endian words. The word at A holds the flags in bits 31:16 and the length in bits 15:0. The word at A+4 holds the buffer pointer. Flag positions in the word are: empty 31, software-own 30, wrap 29, interrupt 28, last 27, first 26, reserved 25, miss 24, and a software byte in 23:16. The pointer word is read only after the flags word shows empty = 1.
- R2: The engine stores data only into a buffer whose descriptor had empty = 1. It writes back the flags/length word with empty = 0 after the buffer's last data byte has been written.
- R3: Frame byte k of a buffer goes to buffer pointer + k. The write uses a word-aligned address and one byte enable. Byte offset 0 uses enable bit 3 and data bits 31:24, and offset 3 uses enable bit 0 and data bits 7:0.
- R4: A buffer that does not end the frame is filled with exactly the programmed maximum length of bytes, and its length field gets that value. The buffer that ends the frame gets the total byte count of the frame in its length field.
- R5: The first bit is 1 only on the first buffer of a frame. The last bit is 1 only on the buffer that ends it. A frame that fits in one buffer has both bits set.
- R6: The miss bit is 1 only on the last buffer, with promiscuous mode on, for a frame whose address-match flag was 0 at its first byte. It is 0 in every other case.
- R7: These fields are written back exactly as fetched: software-own, wrap, interrupt, the reserved bit and the software byte.
- R8: After a descriptor is written back, the ring pointer advances by 8 if the wrap bit is 0. If the wrap bit is 1, the ring pointer reloads the ring base.
- R9: Events are held in status bits 0 (buffer), 1 (frame) and 2 (busy). A written-back descriptor with interrupt = 1 sets the frame event if it was the last buffer, and the buffer event otherwise. With interrupt = 0 it sets no event. Event bits stay set until cleared by a 1 on the matching clear bit.
- R10: The interrupt output is high exactly when some event bit and its mask bit (same positions as R9) are both 1.
- R11: If a descriptor has empty = 0 when a frame starts or continues, the engine drops the rest of the frame and sets the busy event. It writes nothing to memory and keeps the ring pointer, so the next frame retries the same descriptor.
- R12: A byte marked with the error flag is not stored. The current buffer closes as last, with the count of bytes stored so far, and the rest of the frame up to its end marker is dropped.
- R13: While disabled, the engine accepts no stream bytes and issues no memory request, and the ring pointer follows the ring base. After reset all events and the interrupt are 0.
- R14: A memory request keeps its address, write flag, data and byte enables unchanged until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable; low holds the engine idle with the pointer at the base |
| cfg_ring_base | input | ADDR_W | Byte address of the first descriptor of the ring |
| cfg_max_len | input | 16 | Buffer size in bytes (at least 1) |
| cfg_promisc | input | 1 | Promiscuous mode, enables the miss report |
| evt_mask | input | 3 | Interrupt enables for buffer, frame, busy |
| evt_clr | input | 3 | Write-1-to-clear strobes for the event bits |
| evt_status | output | 3 | Sticky event bits |
| irq | output | 1 | Masked OR of the events |
| rx_valid | input | 1 | Stream byte present |
| rx_ready | output | 1 | Stream byte accepted this cycle |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Byte carries an error; aborts the frame |
| rx_addr_hit | input | 1 | Frame matched the station address (sampled with the first byte) |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit 3 is the lowest address |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |

## Verification
Every result here appears only after a chain of memory transactions. Each transaction holds its request until the acknowledge, and the bench's memory answers one cycle after it sees a request. So a data byte is in memory two cycles after it is accepted, and the written-back descriptor and its event bit follow two to three cycles after the frame's final byte. The bench drives stream bytes and samples every port on the falling edge. After each frame it waits a fixed 40 cycles before it reads the modelled memory or the event bits, well past that worst-case tail. The interrupt comes from a mask and the event register through combinational logic, so its check right after a mask change runs 1 ns into the same falling-edge slot.

// File: rtl/rxbd_pkg.sv
`timescale 1ns/1ps
package rxbd_pkg;

    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned LEN_W      = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LANES      = WORD_W / BYTE_W;

    // flag positions inside the first descriptor word
    localparam int unsigned FB_EMPTY = 31;
    localparam int unsigned FB_SWOWN = 30;
    localparam int unsigned FB_WRAP  = 29;
    localparam int unsigned FB_INTR  = 28;
    localparam int unsigned FB_LAST  = 27;
    localparam int unsigned FB_FIRST = 26;
    localparam int unsigned FB_RSVD  = 25;
    localparam int unsigned FB_MISS  = 24;

    // event bit positions
    localparam int unsigned EV_BUF = 0;
    localparam int unsigned EV_FRM = 1;
    localparam int unsigned EV_BSY = 2;
    localparam int unsigned EV_N   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SOF,
        ST_FETCH_FLAGS,
        ST_FETCH_PTR,
        ST_TAKE,
        ST_STORE,
        ST_CLOSE,
        ST_DROP
    } eng_state_e;

endpackage

// File: rtl/rxbd_ring_ptr.sv
`timescale 1ns/1ps
module rxbd_ring_ptr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              advance,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (!enable) begin
            ptr_d = base;
        end else if (advance) begin
            ptr_d = wrap ? base : ptr_q + ADDR_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

    AST_PTR_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ptr_q == $past(base)));                                   // R13

endmodule

// File: rtl/rxbd_event_unit.sv
`timescale 1ns/1ps
module rxbd_event_unit #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] evt,
    output logic         irq
);

    logic [N-1:0] evt_d, evt_q;

    // a new event wins over a clear in the same cycle
    always_comb begin
        evt_d = (evt_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign evt = evt_q;
    assign irq = |(evt_q & mask);

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_q[g] && !clr[g]) |=> evt_q[g]);                               // R9
        AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> evt_q[g]);                                              // R9
    end

endmodule

// File: rtl/rxbd_byte_lane.sv
`timescale 1ns/1ps
module rxbd_byte_lane
    import rxbd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [BYTE_W-1:0] byte_val,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LANES-1:0]  lane_be,
    output logic [WORD_W-1:0] lane_data
);

    localparam int unsigned OFS_W = $clog2(LANES);

    assign word_addr = {byte_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    // big-endian lanes: offset 0 sits in the top byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_be[g] = (byte_addr[OFS_W-1:0] == OFS_W'(LANES - 1 - g));
        assign lane_data[g*BYTE_W +: BYTE_W] = byte_val;
    end

endmodule

// File: rtl/rxbd_ring_engine.sv
`timescale 1ns/1ps
module rxbd_ring_engine
    import rxbd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [15:0]       cfg_max_len,
    input  logic              cfg_promisc,
    input  logic [2:0]        evt_mask,
    input  logic [2:0]        evt_clr,
    output logic [2:0]        evt_status,
    output logic              irq,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic              rx_addr_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);

    localparam int unsigned PTR_OFS = WORD_W / BYTE_W;

    typedef struct packed {
        eng_state_e        st;
        logic [WORD_W-1:0] w0;        // fetched flags/length word
        logic [ADDR_W-1:0] buf_ptr;
        logic [LEN_W-1:0]  cnt;       // bytes in the open buffer
        logic [LEN_W-1:0]  total;     // bytes of the frame so far
        logic [BYTE_W-1:0] dbyte;
        logic              dbyte_eof;
        logic              first;
        logic              last;
        logic              tail;      // rest of frame to be dropped after close
        logic              hit;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic [ADDR_W-1:0] ring_ptr;
    logic              ring_adv;
    logic [EV_N-1:0]   evt_set;
    logic [ADDR_W-1:0] lane_addr;
    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] lane_data;
    logic [WORD_W-1:0] wb_word;

    rxbd_ring_ptr #(
        .ADDR_W (ADDR_W),
        .STEP   (DESC_BYTES)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .advance (ring_adv),
        .wrap    (cur_q.w0[FB_WRAP]),
        .base    (cfg_ring_base),
        .ptr     (ring_ptr)
    );

    rxbd_byte_lane #(
        .ADDR_W (ADDR_W)
    ) u_lane (
        .byte_addr (cur_q.buf_ptr + ADDR_W'(cur_q.cnt)),
        .byte_val  (cur_q.dbyte),
        .word_addr (lane_addr),
        .lane_be   (lane_be),
        .lane_data (lane_data)
    );

    rxbd_event_unit #(
        .N (EV_N)
    ) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_set),
        .clr   (evt_clr),
        .mask  (evt_mask),
        .evt   (evt_status),
        .irq   (irq)
    );

    // status/length word returned to software
    always_comb begin
        wb_word           = cur_q.w0;
        wb_word[FB_EMPTY] = 1'b0;
        wb_word[FB_LAST]  = cur_q.last;
        wb_word[FB_FIRST] = cur_q.first;
        wb_word[FB_MISS]  = cur_q.last & cfg_promisc & ~cur_q.hit;
        wb_word[LEN_W-1:0] = cur_q.last ? cur_q.total : cur_q.cnt;
    end

    always_comb begin
        nxt_d     = cur_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ring_ptr;
        mem_wdata = '0;
        mem_be    = '1;
        rx_ready  = 1'b0;
        ring_adv  = 1'b0;
        evt_set   = '0;

        case (cur_q.st)
            ST_IDLE: begin
                nxt_d.st = ST_WAIT_SOF;
            end

            ST_WAIT_SOF: begin
                if (rx_valid) begin
                    if (rx_sof) begin
                        // hold the first byte until a buffer is ready
                        nxt_d.hit   = rx_addr_hit;
                        nxt_d.first = 1'b1;
                        nxt_d.total = '0;
                        nxt_d.st    = ST_FETCH_FLAGS;
                    end else begin
                        rx_ready = 1'b1;     // stray byte outside a frame
                    end
                end
            end

            ST_FETCH_FLAGS: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    nxt_d.w0 = mem_rdata;
                    if (mem_rdata[FB_EMPTY]) begin
                        nxt_d.st = ST_FETCH_PTR;
                    end else begin
                        evt_set[EV_BSY] = 1'b1;
                        nxt_d.st        = ST_DROP;
                    end
                end
            end

            ST_FETCH_PTR: begin
                mem_req  = 1'b1;
                mem_addr = ring_ptr + ADDR_W'(PTR_OFS);
                if (mem_ack) begin
                    nxt_d.buf_ptr = mem_rdata[ADDR_W-1:0];
                    nxt_d.cnt     = '0;
                    nxt_d.st      = ST_TAKE;
                end
            end

            ST_TAKE: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    if (rx_err) begin
                        nxt_d.last = 1'b1;
                        nxt_d.tail = ~rx_eof;
                        nxt_d.st   = ST_CLOSE;
                    end else begin
                        nxt_d.dbyte     = rx_data;
                        nxt_d.dbyte_eof = rx_eof;
                        nxt_d.st        = ST_STORE;
                    end
                end
            end

            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lane_addr;
                mem_wdata = lane_data;
                mem_be    = lane_be;
                if (mem_ack) begin
                    nxt_d.cnt   = cur_q.cnt + LEN_W'(1);
                    nxt_d.total = cur_q.total + LEN_W'(1);
                    nxt_d.tail  = 1'b0;
                    if (cur_q.dbyte_eof) begin
                        nxt_d.last = 1'b1;
                        nxt_d.st   = ST_CLOSE;
                    end else if (cur_q.cnt + LEN_W'(1) == cfg_max_len) begin
                        nxt_d.last = 1'b0;
                        nxt_d.st   = ST_CLOSE;
                    end else begin
                        nxt_d.st = ST_TAKE;
                    end
                end
            end

            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb_word;
                if (mem_ack) begin
                    ring_adv = 1'b1;
                    if (cur_q.w0[FB_INTR]) begin
                        evt_set[cur_q.last ? EV_FRM : EV_BUF] = 1'b1;
                    end
                    if (cur_q.last) begin
                        nxt_d.st = cur_q.tail ? ST_DROP : ST_WAIT_SOF;
                    end else begin
                        nxt_d.first = 1'b0;
                        nxt_d.st    = ST_FETCH_FLAGS;
                    end
                end
            end

            ST_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_eof) begin
                    nxt_d.st = ST_WAIT_SOF;
                end
            end

            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase

        if (!cfg_enable) begin
            nxt_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && cfg_enable) |=>
        (!cfg_enable || (mem_req && $stable(mem_addr) && $stable(mem_we)
                         && $stable(mem_wdata) && $stable(mem_be))));          // R14

    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1)); // R3

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_TAKE || cur_q.st == ST_STORE) |-> (cur_q.cnt < cfg_max_len)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && cur_q.st == ST_IDLE) |-> (!rx_ready && !mem_req));    // R13

endmodule

// File: tb/rxbd_ring_engine_tb.sv
`timescale 1ns/1ps
module rxbd_ring_engine_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable;
    logic [31:0] cfg_ring_base;
    logic [15:0] cfg_max_len;
    logic        cfg_promisc;
    logic [2:0]  evt_mask;
    logic [2:0]  evt_clr;
    logic [2:0]  evt_status;
    logic        irq;
    logic        rx_valid;
    logic        rx_ready;
    logic [7:0]  rx_data;
    logic        rx_sof, rx_eof, rx_err, rx_addr_hit;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    logic [31:0] mem [0:255];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxbd_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
        .cfg_max_len(cfg_max_len), .cfg_promisc(cfg_promisc), .evt_mask(evt_mask),
        .evt_clr(evt_clr), .evt_status(evt_status), .irq(irq), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .rx_addr_hit(rx_addr_hit), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // memory model: answers one falling edge after a request appears
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && !mem_ack) begin
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[9:2]];
                if (mem_we) begin
                    for (int b = 0; b < 4; b++) begin
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    end
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=completed");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_desc(input logic [31:0] addr, input logic [15:0] flags,
                            input logic [31:0] bptr);
        mem[addr[9:2]]     = {flags, 16'h0000};
        mem[addr[9:2] + 1] = bptr;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic clear_events();
        @(negedge clk);
        evt_clr = 3'b111;
        @(negedge clk);
        evt_clr = 3'b000;
    endtask

    task automatic send_frame(input int n, input int err_at, input logic hit,
                              input logic [7:0] seed);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid    = 1'b1;
            rx_data     = seed + 8'(k);
            rx_sof      = (k == 0);
            rx_eof      = (k == n - 1);
            rx_err      = (k == err_at);
            rx_addr_hit = hit;
            #1;
            while (!rx_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R13 reset events", {29'd0, evt_status}, 32'd0);
        chk("R13 reset irq", {31'd0, irq}, 32'd0);
        chk("R13 disabled no request", {31'd0, mem_req}, 32'd0);
        chk("R13 disabled no ready", {31'd0, rx_ready}, 32'd0);
    endtask

    // one-buffer frame at the ring base
    task automatic t_single();
        set_desc(32'h100, 16'h8000 | 16'h4000 | 16'h1000 | 16'h0200 | 16'h005A, 32'h200);
        mem[8'h81] = 32'hAAAAAAAA;
        send_frame(5, -1, 1'b1, 8'h10);
        settle();
        chk("R1 R2 R5 R7 single writeback", mem[8'h40], 32'h5E5A0005);
        chk("R3 bytes 0-3", mem[8'h80], 32'h10111213);
        chk("R3 byte 4 lane", mem[8'h81], 32'h14AAAAAA);
        chk("R9 frame event", {29'd0, evt_status}, 32'h2);
        chk("R10 irq on frame", {31'd0, irq}, 32'h1);
        clear_events();
        chk("R9 write-1 clear", {29'd0, evt_status}, 32'h0);
    endtask

    // 10 bytes over three 4-byte buffers, wrapping through the base
    task automatic t_multi();
        cfg_max_len = 16'd4;
        cfg_promisc = 1'b1;
        set_desc(32'h108, 16'h9000, 32'h240);
        set_desc(32'h110, 16'hB000, 32'h280);
        set_desc(32'h100, 16'h9000, 32'h2C0);
        send_frame(10, -1, 1'b0, 8'h40);
        settle();
        chk("R4 R5 first buffer", mem[8'h42], 32'h14000004);
        chk("R4 R6 middle buffer", mem[8'h44], 32'h30000004);
        chk("R4 R5 R6 R8 last buffer after wrap", mem[8'h40], 32'h1900000A);
        chk("R3 R4 buffer A", mem[8'h90], 32'h40414243);
        chk("R3 R4 buffer B", mem[8'hA0], 32'h44454647);
        chk("R3 R4 buffer C", mem[8'hB0], 32'h48490000);
        chk("R9 buffer and frame events", {29'd0, evt_status}, 32'h3);
        clear_events();
    endtask

    // descriptor still held by software, then released
    task automatic t_busy();
        cfg_max_len = 16'd16;
        evt_mask    = 3'b011;
        mem[8'h42]  = 32'h10000000;
        mem[8'hC0]  = 32'hDEADBEEF;
        send_frame(3, -1, 1'b1, 8'h60);
        settle();
        chk("R11 busy event", {29'd0, evt_status}, 32'h4);
        chk("R10 busy masked", {31'd0, irq}, 32'h0);
        chk("R11 descriptor untouched", mem[8'h42], 32'h10000000);
        chk("R11 buffer untouched", mem[8'hC0], 32'hDEADBEEF);
        evt_mask = 3'b111;
        #1;
        chk("R10 busy unmasked", {31'd0, irq}, 32'h1);
        clear_events();
        set_desc(32'h108, 16'h9000, 32'h300);
        send_frame(3, -1, 1'b1, 8'h70);
        settle();
        chk("R11 R6 retry same descriptor", mem[8'h42], 32'h1C000003);
        chk("R11 retry data", mem[8'hC0], 32'h707172EF);
        clear_events();
    endtask

    // error byte aborts a frame; the next frame follows the wrap
    task automatic t_error();
        cfg_promisc = 1'b0;
        set_desc(32'h110, 16'hB000, 32'h340);
        mem[8'hD0] = 32'h11111111;
        mem[8'hD1] = 32'h22222222;
        send_frame(6, 3, 1'b1, 8'h80);
        settle();
        chk("R12 aborted writeback", mem[8'h44], 32'h3C000003);
        chk("R12 stored bytes", mem[8'hD0], 32'h80818211);
        chk("R12 rest dropped", mem[8'hD1], 32'h22222222);
        chk("R9 frame event on abort", {29'd0, evt_status}, 32'h2);
        clear_events();
        set_desc(32'h100, 16'h8000, 32'h380);
        mem[8'hE0] = 32'h0;
        send_frame(2, -1, 1'b0, 8'h90);
        settle();
        chk("R8 next after wrap", mem[8'h40], 32'h0C000002);
        chk("R3 next data", mem[8'hE0], 32'h90910000);
        chk("R9 no event without interrupt bit", {29'd0, evt_status}, 32'h0);
    endtask

    // disable ignores the stream and reloads the pointer from the base
    task automatic t_disable();
        @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        rx_valid = 1'b1;
        rx_sof   = 1'b1;
        rx_eof   = 1'b1;
        #1;
        chk("R13 disabled ignores stream", {31'd0, rx_ready}, 32'h0);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        cfg_enable = 1'b1;
        repeat (3) @(negedge clk);
        set_desc(32'h100, 16'h8000, 32'h3C0);
        mem[8'hF0] = 32'h0;
        send_frame(1, -1, 1'b1, 8'hA5);
        settle();
        chk("R13 pointer back at base", mem[8'h40], 32'h0C000001);
        chk("R3 one-byte frame", mem[8'hF0], 32'hA5000000);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        rst_n         = 1'b0;
        cfg_enable    = 1'b0;
        cfg_ring_base = 32'h100;
        cfg_max_len   = 16'd16;
        cfg_promisc   = 1'b0;
        evt_mask      = 3'b111;
        evt_clr       = 3'b000;
        rx_valid      = 1'b0;
        rx_data       = 8'h00;
        rx_sof        = 1'b0;
        rx_eof        = 1'b0;
        rx_err        = 1'b0;
        rx_addr_hit   = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        cfg_enable = 1'b1;
        repeat (3) @(negedge clk);
        t_single();
        t_multi();
        t_busy();
        t_error();
        t_disable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule